// File: doc/BRIEF.md
# Variable-Length PWM Generator with Reload Registers

The block drives a set of pulse-width outputs from one free-running 16-bit counter. A shared 2-bit length field picks how many low counter bits form one PWM period: 8, 9, 10 or 11. Each channel can instead be switched to a wide mode, in which it compares against the whole 16-bit counter and does not use the shared length.

Every channel holds a live compare value and a reload value. Both are reached through the same pair of byte addresses, and a select bit in the configuration register decides which of the two a bus access reaches. In the 9-, 10- and 11-bit lengths, the reload value is copied into the compare value at the end of every period. Duty changes written there therefore take effect on a period boundary. A sticky end-of-period flag, gated by an enable bit, drives the single interrupt line.

Top module: `pwm_vlen`

## Requirements
- R1: After reset every register reads 0, all PWM outputs are low and the interrupt is low. The counter starts at 0 and adds 1 on every clock.
- R2: The length field (config bits 1:0) selects n = 8 + field bits: 00→8, 01→9, 10→10, 11→11. A period ends in a cycle where the low n counter bits are all ones. The end-of-period flag is set at the following clock edge, when those bits wrap to 0.
- R3: The end-of-period flag (config bit 5) stays set until a config write puts 0 in bit 5. A config write with bit 5 = 1 sets it.
- R4: If a period ends in the same cycle as a config write that clears the flag, the flag ends up set.
- R5: irq_o is high exactly when the enable bit (config bit 6) and the flag are both 1.
- R6: With the select bit (config bit 7) at 0, channel byte addresses +1 (low) and +2 (high) read and write the compare value. With it at 1, the same addresses reach the reload value.
- R7: A channel not in wide mode drives 1 while (counter mod 2^n) < (compare mod 2^n), and 0 otherwise.
- R8: At each period end with a length field other than 00, the reload value of every channel not in wide mode is copied into its compare value. This copy wins over a compare write in the same cycle. With length 00 the reload value has no effect.
- R9: A channel whose mode register (base +0, bit 0) is 1 drives 1 while the full 16-bit counter is below its 16-bit compare value. It ignores the length field and is never reloaded.
- R10: Config bits 4:2 always read 0, and writes to them are ignored. Channel k's registers sit at 4 + 4k (mode), 5 + 4k (low byte) and 6 + 4k (high byte). Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe for the addressed register |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| pwm_o | output | 2 | PWM outputs, one per channel |
| irq_o | output | 1 | End-of-period interrupt |

## Verification
Two pairs of actions can land in the same cycle. The first is the hardware setting the end-of-period flag while software clears it. The bench waits until the low counter bits are all ones and then issues the clearing config write in exactly that cycle. The flag must read back as 1, and a clearing write at any other cycle must leave it at 0. The second pair is the reload copy and a compare write. It is covered by sweeping every length over two full periods with the reload value differing from the compare value, and judging each output sample against a cycle-true reference model kept in the bench.

// File: rtl/pwm_vlen_pkg.sv
package pwm_vlen_pkg;
  parameter int unsigned CNT_W     = 16;
  parameter int unsigned BASE_BITS = 8;
  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [1:0]       len_t;

  function automatic cnt_t len_mask(len_t len);
    return (cnt_t'(1) << (BASE_BITS + 32'(len))) - cnt_t'(1);
  endfunction
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_vlen_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  len_t len_i,
  output cnt_t cnt_o,
  output cnt_t mask_o,
  output logic cyc_end_o
);
  cnt_t cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + cnt_t'(1);
  end

  assign cnt_o     = cnt_q;
  assign mask_o    = len_mask(len_i);
  assign cyc_end_o = ((cnt_q & mask_o) == mask_o);
endmodule

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
  import pwm_vlen_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  input  logic       cyc_end_i,
  output logic       sel_o,
  output logic       en_o,
  output logic       flag_o,
  output len_t       len_o,
  output logic [7:0] rdata_o
);
  logic sel_q, en_q, flag_q;
  len_t len_q;
  logic unused_wbits;
  assign unused_wbits = ^wdata_i[4:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= 1'b0;
      en_q   <= 1'b0;
      flag_q <= 1'b0;
      len_q  <= '0;
    end else begin
      if (we_i) begin
        sel_q <= wdata_i[7];
        en_q  <= wdata_i[6];
        len_q <= wdata_i[1:0];
      end
      // hardware set outranks a software clear
      if (cyc_end_i)  flag_q <= 1'b1;
      else if (we_i)  flag_q <= wdata_i[5];
    end
  end

  assign sel_o   = sel_q;
  assign en_o    = en_q;
  assign flag_o  = flag_q;
  assign len_o   = len_q;
  assign rdata_o = {sel_q, en_q, flag_q, 3'b000, len_q};
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_vlen_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_mode_i,
  input  logic       we_lo_i,
  input  logic       we_hi_i,
  input  logic [7:0] wdata_i,
  input  logic       sel_i,
  input  len_t       len_i,
  input  cnt_t       cnt_i,
  input  cnt_t       mask_i,
  input  logic       cyc_end_i,
  output logic       wide_o,
  output cnt_t       cmp_o,
  output cnt_t       rld_o,
  output logic       pwm_o
);
  localparam int unsigned HI_W = CNT_W - 8;

  logic wide_q;
  cnt_t cmp_q, rld_q;
  logic reload;

  assign reload = cyc_end_i && (len_i != 2'b00) && !wide_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wide_q <= 1'b0;
      cmp_q  <= '0;
      rld_q  <= '0;
    end else begin
      if (we_mode_i) wide_q <= wdata_i[0];
      if (reload)                 cmp_q <= rld_q;
      else if (!sel_i && we_lo_i) cmp_q[7:0] <= wdata_i;
      else if (!sel_i && we_hi_i) cmp_q[CNT_W-1:8] <= wdata_i[HI_W-1:0];
      if (sel_i && we_lo_i) rld_q[7:0] <= wdata_i;
      if (sel_i && we_hi_i) rld_q[CNT_W-1:8] <= wdata_i[HI_W-1:0];
    end
  end

  assign wide_o = wide_q;
  assign cmp_o  = cmp_q;
  assign rld_o  = rld_q;
  assign pwm_o  = wide_q ? (cnt_i < cmp_q) : ((cnt_i & mask_i) < (cmp_q & mask_i));
endmodule

// File: rtl/pwm_vlen.sv
module pwm_vlen
  import pwm_vlen_pkg::*;
#(
  parameter int unsigned NUM_CH    = 2,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned CH_BASE   = 4,
  parameter int unsigned CH_STRIDE = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic [NUM_CH-1:0] pwm_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] CFG_ADDR = '0;

  cnt_t cnt, mask;
  logic cyc_end;
  logic sel, en, flag;
  len_t len;
  logic [7:0] cfg_rdata;
  logic [NUM_CH-1:0] wide;
  cnt_t cmp [NUM_CH];
  cnt_t rld [NUM_CH];

  pwm_timebase u_tb (
    .clk_i, .rst_ni, .len_i(len), .cnt_o(cnt), .mask_o(mask), .cyc_end_o(cyc_end)
  );

  pwm_cfg_regs u_cfg (
    .clk_i, .rst_ni,
    .we_i(we_i && (addr_i == CFG_ADDR)),
    .wdata_i, .cyc_end_i(cyc_end),
    .sel_o(sel), .en_o(en), .flag_o(flag), .len_o(len), .rdata_o(cfg_rdata)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(CH_BASE + CH_STRIDE * k);
    pwm_channel u_ch (
      .clk_i, .rst_ni,
      .we_mode_i(we_i && (addr_i == A_MODE)),
      .we_lo_i  (we_i && (addr_i == A_MODE + 1'b1)),
      .we_hi_i  (we_i && (addr_i == A_MODE + 2'd2)),
      .wdata_i, .sel_i(sel), .len_i(len), .cnt_i(cnt), .mask_i(mask),
      .cyc_end_i(cyc_end),
      .wide_o(wide[k]), .cmp_o(cmp[k]), .rld_o(rld[k]), .pwm_o(pwm_o[k])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == CFG_ADDR) rdata_o = cfg_rdata;
    for (int k = 0; k < NUM_CH; k++) begin
      if (addr_i == ADDR_W'(CH_BASE + CH_STRIDE * k))     rdata_o = {7'b0, wide[k]};
      if (addr_i == ADDR_W'(CH_BASE + CH_STRIDE * k + 1)) rdata_o = sel ? rld[k][7:0] : cmp[k][7:0];
      if (addr_i == ADDR_W'(CH_BASE + CH_STRIDE * k + 2)) rdata_o = sel ? rld[k][CNT_W-1:8] : cmp[k][CNT_W-1:8];
    end
  end

  assign irq_o = en & flag;
endmodule

// File: rtl/pwm_vlen_chk.sv
module pwm_vlen_chk
  import pwm_vlen_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        rdata_o,
  input cnt_t              cnt,
  input cnt_t              mask,
  input logic              cyc_end,
  input logic              flag,
  input len_t              len,
  input logic              wide0,
  input cnt_t              cmp0,
  input cnt_t              rld0,
  input logic              pwm0
);
  assert_cycle_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_end |=> ((cnt & $past(mask)) == '0));

  assert_flag_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag && !(we_i && addr_i == '0)) |=> flag);

  assert_hw_set_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_end |=> flag);

  assert_zero_duty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wide0 && ((cmp0 & mask) == '0)) |-> !pwm0);

  assert_reload_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_end && len != 2'b00 && !wide0) |=> (cmp0 == $past(rld0)));

  assert_unused_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == '0) |-> (rdata_o[4:2] == 3'b000));
endmodule

bind pwm_vlen pwm_vlen_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i), .rdata_o(rdata_o),
  .cnt(cnt), .mask(mask), .cyc_end(cyc_end), .flag(flag), .len(len),
  .wide0(wide[0]), .cmp0(cmp[0]), .rld0(rld[0]), .pwm0(pwm_o[0])
);

// File: tb/pwm_vlen_tb_top.sv
module pwm_vlen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] pwm;
  logic       irq;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwm_vlen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pwm_o(pwm), .irq_o(irq)
  );

  // reference model built from the requirements
  logic [15:0] m_cnt, m_cmp0, m_rld0, m_cmp1;
  logic [1:0]  m_len;
  logic        m_sel, m_en, m_flag;

  function automatic logic [15:0] msk(logic [1:0] l);
    return (16'd256 << l) - 16'd1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= '0; m_cmp0 <= '0; m_rld0 <= '0; m_cmp1 <= '0;
      m_len <= '0; m_sel <= 1'b0; m_en <= 1'b0; m_flag <= 1'b0;
    end else begin
      automatic logic cyc = ((m_cnt & msk(m_len)) == msk(m_len));
      m_cnt <= m_cnt + 16'd1;
      if (we && addr == 4'd0) begin
        m_sel <= wdata[7]; m_en <= wdata[6]; m_len <= wdata[1:0];
        m_flag <= cyc | wdata[5];
      end else if (cyc) m_flag <= 1'b1;
      if (cyc && m_len != 2'b00) m_cmp0 <= m_rld0;
      else if (we && !m_sel && addr == 4'd5) m_cmp0[7:0] <= wdata;
      else if (we && !m_sel && addr == 4'd6) m_cmp0[15:8] <= wdata;
      if (we && m_sel && addr == 4'd5) m_rld0[7:0] <= wdata;
      if (we && m_sel && addr == 4'd6) m_rld0[15:8] <= wdata;
      if (we && !m_sel && addr == 4'd9)  m_cmp1[7:0] <= wdata;
      if (we && !m_sel && addr == 4'd10) m_cmp1[15:8] <= wdata;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [15:0] c, r;
    repeat (3) @(negedge clk);
    // R1: reset state
    foreach (d[i]) ; // no-op
    for (int a = 0; a < 12; a++) begin
      rd(4'(a), d);
      chk(d == 8'h00, "R1 reset readback", d, 0);
    end
    chk(pwm == 2'b00, "R1 pwm low in reset", pwm, 0);
    chk(irq == 1'b0, "R1 irq low in reset", irq, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(pwm == 2'b00, "R1 pwm low after reset", pwm, 0);

    // R10: unused config bits
    wr(4'd0, 8'h1C);
    rd(4'd0, d);
    chk(d == 8'h00, "R10 unused bits read 0", d, 0);

    // channel 1 in wide mode, compare 0x1000
    wr(4'd8, 8'h01);
    wr(4'd9, 8'h00);
    wr(4'd10, 8'h10);
    rd(4'd8, d);
    chk(d == 8'h01, "R9 wide mode readback", d, 1);

    for (int l = 0; l < 4; l++) begin
      c = 16'(40 << l);
      r = 16'(200 << l);
      wr(4'd0, {1'b1, 5'b0, 2'(l)});     // select reload
      wr(4'd5, r[7:0]);
      wr(4'd6, r[15:8]);
      wr(4'd9, 8'h10);                    // R9: ch1 reload, must not matter
      wr(4'd10, 8'h00);
      rd(4'd5, d); chk(d == r[7:0],  "R6 reload low via alias", d, r[7:0]);
      rd(4'd6, d); chk(d == r[15:8], "R6 reload high via alias", d, r[15:8]);
      wr(4'd0, {1'b0, 5'b0, 2'(l)});     // select compare, clear flag
      wr(4'd5, c[7:0]);
      wr(4'd6, c[15:8]);
      for (int s = 0; s < 2 * (256 << l) + 4; s++) begin
        chk(pwm[0] == ((m_cnt & msk(m_len)) < (m_cmp0 & msk(m_len))), "R7 R8 ch0 output", pwm[0],
            ((m_cnt & msk(m_len)) < (m_cmp0 & msk(m_len))));
        chk(pwm[1] == (m_cnt < m_cmp1), "R9 wide output", pwm[1], (m_cnt < m_cmp1));
        rd(4'd0, d);
        chk(d[5] == m_flag, "R2 flag at period end", d[5], m_flag);
        @(negedge clk);
      end
      rd(4'd5, d);
      if (l == 0) chk(d == c[7:0], "R8 no reload at 8 bits", d, c[7:0]);
      else        chk(d == r[7:0], "R8 reload copied", d, r[7:0]);
      rd(4'd9, d);
      chk(d == 8'h00, "R9 wide channel not reloaded", d, 0);
    end

    // R2: flag at exact period end for 9-bit length
    wr(4'd0, 8'h01);
    while ((m_cnt & 16'h01FF) != 16'h0100) @(negedge clk);
    wr(4'd0, 8'h01);                     // clear, far from period end
    rd(4'd0, d); chk(d[5] == 1'b0, "R3 clear", d[5], 0);
    while ((m_cnt & 16'h01FF) != 16'h01FF) @(negedge clk);
    rd(4'd0, d); chk(d[5] == 1'b0, "R2 flag clear before end", d[5], 0);
    @(negedge clk);
    rd(4'd0, d); chk(d[5] == 1'b1, "R2 flag set after end", d[5], 1);
    repeat (5) @(negedge clk);
    rd(4'd0, d); chk(d[5] == 1'b1, "R3 flag sticky", d[5], 1);

    // R4: clear in the period-end cycle loses
    wr(4'd0, 8'h00);
    while ((m_cnt & 16'h00FF) != 16'h00FF) @(negedge clk);
    wr(4'd0, 8'h00);
    rd(4'd0, d); chk(d[5] == 1'b1, "R4 hw set beats clear", d[5], 1);
    wr(4'd0, 8'h00);
    rd(4'd0, d); chk(d[5] == 1'b0, "R3 clear off-boundary", d[5], 0);
    wr(4'd0, 8'h20);
    rd(4'd0, d); chk(d[5] == 1'b1, "R3 software set", d[5], 1);

    // R5: interrupt gating
    chk(irq == 1'b0, "R5 irq masked", irq, 0);
    wr(4'd0, 8'h60);
    chk(irq == 1'b1, "R5 irq enabled and flag", irq, 1);
    while ((m_cnt & 16'h00FF) == 16'h00FF) @(negedge clk);
    wr(4'd0, 8'h40);
    chk(irq == m_flag, "R5 irq follows flag", irq, m_flag);
    chk(irq == 1'b0, "R5 irq low flag clear", irq, 0);
    wr(4'd0, 8'h20);
    chk(irq == 1'b0, "R5 flag set but disabled", irq, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule